// File: doc/BRIEF.md
# Blocking Direct-Mapped Write-Back Data Cache

This block is a data cache placed between a processor load/store port and a slower memory. It keeps one cached line per index. A lookup that finds a valid line with a matching tag finishes in the same cycle. It returns a read word or stores a write word, and memory is not touched. Every other lookup stalls the processor. A modified victim is first copied out to memory. The wanted block is then fetched, and the original request is replayed against the freshly filled line.

Writes use the write-back policy with write-allocate. A store to a cached line changes only the cache copy and marks the line modified. A store that misses first brings the whole block in and then merges the new word. Memory traffic always moves one full four-word block per transaction, under a request/ready handshake.

The controller has four states. ST_LOOKUP compares tags and serves hits. ST_WRBACK writes the victim out. ST_FILL reads the new block. ST_RETRY replays the request on the filled line. The transitions are as follows:
- ST_LOOKUP goes to ST_WRBACK on a miss whose victim is valid and modified.
- ST_LOOKUP goes to ST_FILL on any other miss.
- ST_WRBACK goes to ST_FILL when memory accepts the write.
- ST_FILL goes to ST_RETRY when the read data arrives.
- ST_RETRY always returns to ST_LOOKUP.

Top module: `dmc_cache`

## Requirements
- R1: After reset no line is valid, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R2: A 32-bit byte address is split three ways. Bits 31..14 form the tag, bits 13..4 select one of 1024 lines, and bits 3..2 select the word inside the 16-byte line. Addresses with different indices never share a line, and addresses with the same index but different tags always do.
- R3: A hit requires the selected line to be valid and its stored tag to equal the address tag. A hit completes in the cycle it is presented, with `cpu_ready` and `cpu_hit` both high and no memory transaction.
- R4: A read returns the 32-bit word chosen by address bits 3..2 from the line.
- R5: A write hit replaces only the selected word and marks the line modified. It causes no memory write.
- R6: On a miss whose victim is valid and modified, the full victim block is written first. The write address is the victim's stored tag and the index, with bits 3..0 zero. Word w of a block occupies bits 32w+31..32w of `mem_wdata` and `mem_rdata`.
- R7: A miss whose victim is clean or invalid performs no memory write.
- R8: A write miss fetches the block, then merges the written word and marks the line modified. The other words keep their memory values.
- R9: A refill stores the block as valid and clean. The replayed request then completes with `cpu_hit` low, and a read returns the word from the fetched block.
- R10: The cache is blocking. `cpu_ready` stays low from the missing lookup until the replay cycle.
- R11: `mem_req`, `mem_we` and `mem_addr` stay constant while a request waits for `mem_ready`. Each transaction moves exactly one block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Completing access hit on first lookup |
| mem_req | output | 1 | Memory block transaction request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_wdata | output | 128 | Block being written out |
| mem_rdata | input | 128 | Block returned by memory |
| mem_ready | input | 1 | Memory completes the transaction this cycle |

## Verification
The hardest situation to reach from the ports is an eviction whose written-back block mixes a word stored by the processor with words that came from memory. It needs three accesses in order to one index under two tags: a fill, then a write hit, then a conflicting access. The bench builds this chain on purpose. A second chain starts with a write miss and then forces that line out. The bench's memory model records each written-back block, so the merged word, the untouched words and the victim address are all compared. A clean eviction on the same index checks that no second write occurs.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_WRBACK = 2'd1,
        ST_FILL   = 2'd2,
        ST_RETRY  = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             fill_we,
    input  logic             dirty_set,
    output logic [TAG_W-1:0] tag_q,
    output logic             valid_q,
    output logic             dirty_q
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_arr [LINES];
    logic [LINES-1:0] valid_bits;
    logic [LINES-1:0] dirty_bits;

    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_arr[idx] <= tag_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_bits <= '0;
            dirty_bits <= '0;
        end else if (fill_we) begin
            valid_bits[idx] <= 1'b1;
            dirty_bits[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_bits[idx] <= 1'b1;
        end
    end

    assign tag_q   = tag_arr[idx];
    assign valid_q = valid_bits[idx];
    assign dirty_q = dirty_bits[idx];

    // R9
    fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (valid_q && !dirty_q));

    // R5
    dirty_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_set && !fill_we) |=> dirty_q);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
    parameter int IDX_W  = 10,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                      clk,
    input  logic [IDX_W-1:0]          idx,
    input  logic [$clog2(WORDS)-1:0]  wsel,
    input  logic                      fill_we,
    input  logic [WORDS*WORD_W-1:0]   fill_line,
    input  logic                      word_we,
    input  logic [WORD_W-1:0]         word_in,
    output logic [WORDS*WORD_W-1:0]   line_q
);
    localparam int LINES = 1 << IDX_W;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] bank [LINES];

        always_ff @(posedge clk) begin
            if (fill_we) begin
                bank[idx] <= fill_line[w*WORD_W +: WORD_W];
            end else if (word_we && (wsel == w)) begin
                bank[idx] <= word_in;
            end
        end

        assign line_q[w*WORD_W +: WORD_W] = bank[idx];
    end
endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       lookup_hit,
    input  logic       victim_dirty,
    input  logic       mem_ready,
    output dmc_state_e state,
    output logic       cpu_ready,
    output logic       cpu_hit,
    output logic       mem_req,
    output logic       mem_we,
    output logic       victim_sel,
    output logic       fill_we,
    output logic       word_we,
    output logic       dirty_set
);
    dmc_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOOKUP;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        cpu_ready  = 1'b0;
        cpu_hit    = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        victim_sel = 1'b0;
        fill_we    = 1'b0;
        word_we    = 1'b0;
        dirty_set  = 1'b0;
        unique case (state)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (lookup_hit) begin
                        cpu_ready = 1'b1;
                        cpu_hit   = 1'b1;
                        word_we   = cpu_we;
                        dirty_set = cpu_we;
                    end else if (victim_dirty) begin
                        state_nx = ST_WRBACK;
                    end else begin
                        state_nx = ST_FILL;
                    end
                end
            end
            ST_WRBACK: begin
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                victim_sel = 1'b1;
                if (mem_ready) state_nx = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    fill_we  = 1'b1;
                    state_nx = ST_RETRY;
                end
            end
            ST_RETRY: begin
                cpu_ready = 1'b1;
                word_we   = cpu_we;
                dirty_set = cpu_we;
                state_nx  = ST_LOOKUP;
            end
            default: state_nx = ST_LOOKUP;
        endcase
    end

    // R10
    stall_in_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRBACK || state == ST_FILL) |-> !cpu_ready);

    // R3
    lookup_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP) |-> !mem_req);

    // R6
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRBACK && mem_ready) |=> (state == ST_FILL));

    // R9
    fill_then_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && mem_ready) |=> (state == ST_RETRY));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [WORD_W-1:0]       cpu_wdata,
    output logic [WORD_W-1:0]       cpu_rdata,
    output logic                    cpu_ready,
    output logic                    cpu_hit,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORDS*WORD_W-1:0] mem_wdata,
    input  logic [WORDS*WORD_W-1:0] mem_rdata,
    input  logic                    mem_ready
);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = WSEL_W + BYTE_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic [TAG_W-1:0]  addr_tag;
    logic [IDX_W-1:0]  addr_idx;
    logic [WSEL_W-1:0] addr_wsel;
    logic [BYTE_W-1:0] unused_byte;

    assign addr_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign addr_idx    = cpu_addr[OFF_W +: IDX_W];
    assign addr_wsel   = cpu_addr[BYTE_W +: WSEL_W];
    assign unused_byte = cpu_addr[BYTE_W-1:0];

    logic [TAG_W-1:0] line_tag;
    logic             line_valid;
    logic             line_dirty;
    logic             lookup_hit;
    logic             victim_sel;
    logic             fill_we;
    logic             word_we;
    logic             dirty_set;
    dmc_state_e       state;
    logic [WORDS*WORD_W-1:0] line_data;

    dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (addr_idx),
        .tag_in    (addr_tag),
        .fill_we   (fill_we),
        .dirty_set (dirty_set),
        .tag_q     (line_tag),
        .valid_q   (line_valid),
        .dirty_q   (line_dirty)
    );

    dmc_data_store #(.IDX_W(IDX_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_data (
        .clk       (clk),
        .idx       (addr_idx),
        .wsel      (addr_wsel),
        .fill_we   (fill_we),
        .fill_line (mem_rdata),
        .word_we   (word_we),
        .word_in   (cpu_wdata),
        .line_q    (line_data)
    );

    assign lookup_hit = line_valid && (line_tag == addr_tag);

    dmc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .lookup_hit   (lookup_hit),
        .victim_dirty (line_valid && line_dirty),
        .mem_ready    (mem_ready),
        .state        (state),
        .cpu_ready    (cpu_ready),
        .cpu_hit      (cpu_hit),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .victim_sel   (victim_sel),
        .fill_we      (fill_we),
        .word_we      (word_we),
        .dirty_set    (dirty_set)
    );

    assign cpu_rdata = line_data[addr_wsel*WORD_W +: WORD_W];
    assign mem_wdata = line_data;
    assign mem_addr  = {(victim_sel ? line_tag : addr_tag), addr_idx, {OFF_W{1'b0}}};

    // R9
    retry_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETRY) |-> lookup_hit);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // R3
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (cpu_ready && line_valid));

    // R6
    wb_victim_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (line_valid && line_dirty && !lookup_hit));
endmodule

// File: tb/tb_dmc_cache.sv
module tb_dmc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         cpu_hit;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int n_wb = 0;
    int n_fill = 0;
    logic [31:0]  last_wb_addr = '0;
    logic [127:0] last_wb_data = '0;
    logic [127:0] bmem [int unsigned];
    int lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmc_cache dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [31:0] pat(input int unsigned blk, input int w);
        return 32'h5000_0001 ^ (blk << 4) ^ (32'(w) << 2);
    endfunction

    function automatic logic [127:0] mem_line(input int unsigned blk);
        logic [127:0] l;
        if (bmem.exists(blk)) return bmem[blk];
        for (int w = 0; w < 4; w++) l[w*32 +: 32] = pat(blk, w);
        return l;
    endfunction

    function automatic logic [31:0] mk(input int tag, input int idx, input int w);
        return {tag[17:0], idx[9:0], w[1:0], 2'b00};
    endfunction

    // Memory model: three cycles of latency, one-cycle ready pulse per block.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            mem_ready <= 1'b0;
            lat <= 0;
        end else if (mem_req && !mem_ready) begin
            if (lat == 2) begin
                lat <= 0;
                mem_ready <= 1'b1;
                if (mem_we) begin
                    bmem[mem_addr >> 4] = mem_wdata;
                    n_wb <= n_wb + 1;
                    last_wb_addr <= mem_addr;
                    last_wb_data <= mem_wdata;
                end else begin
                    mem_rdata <= mem_line(mem_addr >> 4);
                    n_fill <= n_fill + 1;
                end
            end else begin
                lat <= lat + 1;
            end
        end else begin
            mem_ready <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output logic h, output int stall);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        stall = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
            stall++;
        end
        rd = cpu_rdata; h = cpu_hit;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    logic [31:0] rd;
    logic h;
    int st;
    int wb0, fill0;

    task automatic t_reset();
        #1;
        check("R1 ready low", cpu_ready, 0);
        check("R1 mem_req low", mem_req, 0);
    endtask

    task automatic t_read_miss_hit();
        fill0 = n_fill; wb0 = n_wb;
        access(0, mk(5, 'h123, 2), 0, rd, h, st);
        check("R1 first access misses", h, 0);
        check("R9 read miss data", rd, pat(mk(5, 'h123, 0) >> 4, 2));
        check("R7 no write on clean miss", n_wb, wb0);
        check("R11 one fill", n_fill, fill0 + 1);
        check("R10 stalled during miss", st > 2, 1);
        access(0, mk(5, 'h123, 2), 0, rd, h, st);
        check("R3 reread hits", h, 1);
        check("R3 hit no stall", st, 0);
        check("R3 hit no fill", n_fill, fill0 + 1);
        access(0, mk(5, 'h123, 0), 0, rd, h, st);
        check("R4 word 0 select", rd, pat(mk(5, 'h123, 0) >> 4, 0));
    endtask

    task automatic t_write_hit();
        wb0 = n_wb;
        access(1, mk(5, 'h123, 1), 32'hDEAD_BEEF, rd, h, st);
        check("R5 write hit", h, 1);
        check("R5 no memory write", n_wb, wb0);
        check("R5 memory unchanged", bmem.exists(mk(5, 'h123, 0) >> 4), 0);
        access(0, mk(5, 'h123, 1), 0, rd, h, st);
        check("R5 written word", rd, 32'hDEAD_BEEF);
        access(0, mk(5, 'h123, 3), 0, rd, h, st);
        check("R5 neighbour word kept", rd, pat(mk(5, 'h123, 0) >> 4, 3));
    endtask

    task automatic t_dirty_evict();
        logic [127:0] exp;
        wb0 = n_wb;
        exp = mem_line(mk(5, 'h123, 0) >> 4);
        exp[63:32] = 32'hDEAD_BEEF;
        access(0, mk(9, 'h123, 0), 0, rd, h, st);
        check("R2 same index other tag misses", h, 0);
        check("R6 one write-back", n_wb, wb0 + 1);
        check("R6 victim address", last_wb_addr, mk(5, 'h123, 0));
        check("R6 victim data", last_wb_data, exp);
        check("R9 new data", rd, pat(mk(9, 'h123, 0) >> 4, 0));
    endtask

    task automatic t_clean_evict();
        wb0 = n_wb;
        access(0, mk(5, 'h123, 1), 0, rd, h, st);
        check("R7 clean victim no write", n_wb, wb0);
        check("R9 data back from memory", rd, 32'hDEAD_BEEF);
    endtask

    task automatic t_write_miss();
        logic [127:0] exp;
        wb0 = n_wb; fill0 = n_fill;
        access(1, mk(7, 'h2A0, 3), 32'h1234_5678, rd, h, st);
        check("R8 write miss reports miss", h, 0);
        check("R8 block fetched", n_fill, fill0 + 1);
        check("R8 no write-back", n_wb, wb0);
        access(0, mk(7, 'h2A0, 3), 0, rd, h, st);
        check("R8 merged word", rd, 32'h1234_5678);
        access(0, mk(7, 'h2A0, 0), 0, rd, h, st);
        check("R8 other word from memory", rd, pat(mk(7, 'h2A0, 0) >> 4, 0));
        exp = mem_line(mk(7, 'h2A0, 0) >> 4);
        exp[127:96] = 32'h1234_5678;
        access(0, mk(8, 'h2A0, 0), 0, rd, h, st);
        check("R8 line was dirty", n_wb, wb0 + 1);
        check("R6 write-miss victim data", last_wb_data, exp);
    endtask

    task automatic t_index_edges();
        access(0, mk(1, 0, 0), 0, rd, h, st);
        access(0, mk(1, 1023, 3), 0, rd, h, st);
        check("R2 index 1023 data", rd, pat(mk(1, 1023, 0) >> 4, 3));
        access(0, mk(1, 0, 0), 0, rd, h, st);
        check("R2 index 0 kept", h, 1);
        access(0, mk('h3FFFF, 1023, 2), 0, rd, h, st);
        check("R2 top tag misses", h, 0);
        check("R2 top tag data", rd, pat(mk('h3FFFF, 1023, 0) >> 4, 2));
        access(0, mk(1, 0, 0), 0, rd, h, st);
        check("R2 index 0 still hits", h, 1);
    endtask

    initial begin
        while (cycles < WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_read_miss_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_index_edges();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule